// File: doc/BRIEF.md
# CAN Bit Timing Sampler

This block derives the bit timing of a CAN receiver from the system clock and samples the receive line once per bit. A prescaler divides the system clock into time quanta. Each bit time is one synchronisation quantum followed by two programmable segments. The sample point sits at the boundary between the first and the second segment. The bit is decided either from the single value on the line at the sample point, or from a majority vote over three samples.

Configuration lives in two byte-wide registers. Software can read them at any time, but the block accepts writes only while initialization mode is both requested and acknowledged. While that mode is active, the timing counters stay at their start and no bits are produced. When the mode ends, the first bit time begins on the next clock.

Each decided bit is reported as a one-clock strobe, with its value on a separate output. The value holds until the next strobe. The receive input is assumed to be already synchronised to the system clock.

Top module: `can_bit_sampler`

## Requirements
- R1: After reset both registers read 0x00 and the bit strobe is low.
- R2: The prescaler field (address 0, bits 5:0) sets the quantum length to field+1 system clocks, from 1 to 64. Bits 7:6 of address 0 read as zero.
- R3: The first segment is seg1+1 quanta long and the second segment is seg2+1 quanta long. Strobes while running are spaced exactly (seg1+seg2+3)·P clocks apart, where P is the quantum length.
- R4: On leaving init mode, the clock edge that ends quantum number seg1+1 is the sample point. Quantum 0 is the sync quantum. That edge falls (seg1+2)·P edges after the exit, and the strobe is high during the clock that follows it.
- R5: In single-sample mode (address 1, bit 7 = 0), the bit value equals the receive line at the sample-point edge.
- R6: In triple-sample mode, the bit value is the majority of three values of the line, taken at the edges ending quanta seg1−1, seg1 and seg1+1. A single wrong sample is therefore masked.
- R7: Triple-sample mode takes effect only when the seg1 field is at least 1, so that the first segment is at least 2 quanta long. Otherwise the block decides from a single sample.
- R8: Address 1 holds the sample mode in bit 7, seg2 in bits 6:4 and seg1 in bits 3:0. Both registers can be read back at any time, including while the timing runs.
- R9: A write changes a register only when init_req and init_ack are both high. Writes at any other time are ignored.
- R10: While init mode is active, no strobe is produced and the bit timing restarts from its beginning.
- R11: The bit strobe is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | Initialization mode requested |
| init_ack | input | 1 | Initialization mode acknowledged |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 = prescaler, 1 = timing |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 = prescaler, 1 = timing |
| rd_data | output | 8 | Read data (combinational) |
| rx_in | input | 1 | Synchronised receive line |
| bit_strobe | output | 1 | One-clock pulse, one clock after the sample point |
| bit_value | output | 1 | Decided bit value, valid with the strobe |

## Verification
The smallest configuration runs with a random receive line. There, a strobe placed one quantum early or late, or a wrong bit length, shows up at once against the model. The largest prescaler with the longest segments separates a prescaler or segment field that is decoded correctly from one that is cut short.

Glitches one clock wide are placed on the sample-point edge and on an earlier vote edge, with the line otherwise constant. They separate single-sample from majority decisions, and show whether the vote masks a lone bad sample. The same glitch with a one-quantum first segment shows the fallback to single sampling. Writes made with only one of the two init inputs high show whether the configuration is guarded.

// File: rtl/can_bt_pkg.sv
// Shared widths and the timing configuration type for the CAN bit timing sampler.
package can_bt_pkg;
    parameter int REG_W   = 8;   // register width in bits
    parameter int PRESC_W = 6;   // prescaler field width
    parameter int SEG1_W  = 4;   // first segment field width
    parameter int SEG2_W  = 3;   // second segment field width
    localparam int SEG_MAX_W = (SEG1_W > SEG2_W) ? SEG1_W : SEG2_W;
    localparam int QIDX_W    = SEG_MAX_W + 2; // holds up to 1 + 2^SEG1_W + 2^SEG2_W

    typedef struct packed {
        logic              triple;
        logic [SEG2_W-1:0] seg2;
        logic [SEG1_W-1:0] seg1;
    } bt_cfg_t;
endpackage

// File: rtl/can_bt_regs.sv
// Configuration registers: the prescaler and the timing byte.
// Assumes 1 + SEG1_W + SEG2_W <= REG_W and PRESC_W <= REG_W. Writes land only
// when wr_allow is high. Reads are combinational and always available.
module can_bt_regs
    import can_bt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_allow,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               rd_addr,
    output logic [REG_W-1:0]   rd_data,
    output logic [PRESC_W-1:0] presc_q,
    output bt_cfg_t            cfg_q
);
    logic [REG_W-1:0] tim_word;

    // Register update, gated by init mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            cfg_q   <= '0;
        end else if (wr_allow && wr_en) begin
            if (!wr_addr) begin
                presc_q <= wr_data[PRESC_W-1:0];
            end else begin
                cfg_q.triple <= wr_data[REG_W-1];
                cfg_q.seg2   <= wr_data[SEG1_W+SEG2_W-1:SEG1_W];
                cfg_q.seg1   <= wr_data[SEG1_W-1:0];
            end
        end
    end

    // Pack the timing fields back into their byte positions.
    always_comb begin
        tim_word = '0;
        tim_word[REG_W-1] = cfg_q.triple;
        tim_word[SEG1_W+SEG2_W-1:0] = {cfg_q.seg2, cfg_q.seg1};
    end

    // Read mux.
    always_comb begin
        rd_data = rd_addr ? tim_word : REG_W'(presc_q);
    end
endmodule

// File: rtl/can_bt_prescaler.sv
// Time quantum generator: emits one tick every presc_q+1 clocks.
// Assumes presc_q changes only while hold is high.
module can_bt_prescaler
    import can_bt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic [PRESC_W-1:0] presc_q,
    output logic [PRESC_W-1:0] pcnt,
    output logic               tick
);
    // Clock divider counter, cleared while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            pcnt <= '0;
        end else if (pcnt == presc_q) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    // Quantum boundary: the last clock of a quantum.
    always_comb tick = !hold && (pcnt == presc_q);
endmodule

// File: rtl/can_bt_seq.sv
// Quantum sequencer: counts quanta through sync, segment 1 and segment 2.
// Flags the quantum boundaries used for sampling. Index 0 is the sync quantum.
// The sample point ends quantum seg1+1. Assumes the configuration is static
// while not held.
module can_bt_seq
    import can_bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              tick,
    input  bt_cfg_t           cfg_q,
    output logic [QIDX_W-1:0] qidx,
    output logic [QIDX_W-1:0] qlast,
    output logic              early_evt,
    output logic              mid_evt,
    output logic              sp_evt
);
    logic [QIDX_W-1:0] sp_idx;

    // Derived positions within the bit time.
    always_comb begin
        sp_idx    = QIDX_W'(cfg_q.seg1) + QIDX_W'(1);
        qlast     = QIDX_W'(cfg_q.seg1) + QIDX_W'(cfg_q.seg2) + QIDX_W'(2);
        sp_evt    = tick && (qidx == sp_idx);
        mid_evt   = tick && (qidx == QIDX_W'(cfg_q.seg1));
        early_evt = tick && (qidx == QIDX_W'(cfg_q.seg1) - QIDX_W'(1));
    end

    // Quantum index, wrapping after the last quantum of segment 2.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            qidx <= '0;
        end else if (tick) begin
            qidx <= (qidx == qlast) ? '0 : qidx + 1'b1;
        end
    end
endmodule

// File: rtl/can_bt_vote.sv
// Bit decision: captures two early samples, then decides at the sample point.
// The decision is the line itself, or a majority of three when triple_ok.
// Assumes rx_in is already synchronous to clk.
module can_bt_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic rx_in,
    input  logic triple_ok,
    input  logic early_evt,
    input  logic mid_evt,
    input  logic sp_evt,
    output logic bit_strobe,
    output logic bit_value
);
    logic smp_a, smp_b, maj;

    // Early sample capture for the vote.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_a <= 1'b0;
            smp_b <= 1'b0;
        end else begin
            if (early_evt) smp_a <= rx_in;
            if (mid_evt)   smp_b <= rx_in;
        end
    end

    // Two-of-three majority.
    always_comb maj = (smp_a & smp_b) | (smp_a & rx_in) | (smp_b & rx_in);

    // Registered strobe and held bit value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_strobe <= 1'b0;
            bit_value  <= 1'b0;
        end else if (hold) begin
            bit_strobe <= 1'b0;
        end else begin
            bit_strobe <= sp_evt;
            if (sp_evt) bit_value <= triple_ok ? maj : rx_in;
        end
    end
endmodule

// File: rtl/can_bit_sampler.sv
// CAN bit timing sampler top: registers, quantum prescaler, quantum sequencer
// and bit decision. Init mode (request and acknowledge both high) unlocks
// writes and holds the timing at its start.
module can_bit_sampler
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             init_ack,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             rx_in,
    output logic             bit_strobe,
    output logic             bit_value
);
    logic               init_on;
    logic [PRESC_W-1:0] presc_q;
    bt_cfg_t            cfg_q;
    logic [PRESC_W-1:0] pcnt;
    logic               tick;
    logic [QIDX_W-1:0]  qidx, qlast;
    logic               early_evt, mid_evt, sp_evt;
    logic               triple_ok;

    // Init mode needs both handshake halves.
    always_comb init_on = init_req && init_ack;
    // Voting needs a first segment of at least two quanta.
    always_comb triple_ok = cfg_q.triple && (cfg_q.seg1 != '0);

    can_bt_regs i_regs (
        .clk(clk), .rst_n(rst_n), .wr_allow(init_on), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .presc_q(presc_q), .cfg_q(cfg_q)
    );

    can_bt_prescaler i_presc (
        .clk(clk), .rst_n(rst_n), .hold(init_on), .presc_q(presc_q),
        .pcnt(pcnt), .tick(tick)
    );

    can_bt_seq i_seq (
        .clk(clk), .rst_n(rst_n), .hold(init_on), .tick(tick), .cfg_q(cfg_q),
        .qidx(qidx), .qlast(qlast), .early_evt(early_evt), .mid_evt(mid_evt),
        .sp_evt(sp_evt)
    );

    can_bt_vote i_vote (
        .clk(clk), .rst_n(rst_n), .hold(init_on), .rx_in(rx_in),
        .triple_ok(triple_ok), .early_evt(early_evt), .mid_evt(mid_evt),
        .sp_evt(sp_evt), .bit_strobe(bit_strobe), .bit_value(bit_value)
    );
endmodule

// File: rtl/can_bit_sampler_chk.sv
// Property checker for the CAN bit timing sampler, bound into the top module.
module can_bit_sampler_chk
    import can_bt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               init_req,
    input logic               init_ack,
    input logic               bit_strobe,
    input logic [PRESC_W-1:0] presc_q,
    input bt_cfg_t            cfg_q,
    input logic [PRESC_W-1:0] pcnt,
    input logic [QIDX_W-1:0]  qidx,
    input logic [QIDX_W-1:0]  qlast
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (presc_q == '0 && cfg_q == '0 && !bit_strobe));

    // R9
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_req && init_ack) |=> ($stable(presc_q) && $stable(cfg_q)));

    // R10
    init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && init_ack) |=> (!bit_strobe && pcnt == '0 && qidx == '0));

    // R11
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |=> !bit_strobe);

    // R2
    presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= presc_q);

    // R3
    quanta_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qidx <= qlast);
endmodule

bind can_bit_sampler can_bit_sampler_chk i_chk (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .bit_strobe(bit_strobe), .presc_q(presc_q), .cfg_q(cfg_q), .pcnt(pcnt),
    .qidx(qidx), .qlast(qlast)
);

// File: tb/test_can_bit_sampler.sv
// Self-checking bench for the CAN bit timing sampler, using a behavioural
// per-clock reference model.
module test_can_bit_sampler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_req = 1'b0, init_ack = 1'b0;
    logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rx_in = 1'b1;
    logic       bit_strobe, bit_value;

    int checks = 0, failures = 0;
    bit done = 0;

    // Model state.
    int m_presc = 0, m_trip = 0, m_s1 = 0, m_s2 = 0;
    int k = 0, sa = 0, sb = 0, cyc = 0, last_sp = -1;
    bit exp_s = 0, exp_v = 0;
    // Glitch control.
    bit glit_en = 0, glit_base = 1, glit_exp = 1;
    int glit_pos = 0;
    string glit_tag = "";

    can_bit_sampler i_can_bit_sampler (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .rx_in(rx_in), .bit_strobe(bit_strobe),
        .bit_value(bit_value)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int bit_len();
        return (m_s1 + m_s2 + 3) * (m_presc + 1);
    endfunction

    // Reference model: advances on every clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            k = 0; exp_s = 0; exp_v = 0;
            m_presc = 0; m_trip = 0; m_s1 = 0; m_s2 = 0;
        end else if (init_req && init_ack) begin
            k = 0; exp_s = 0;
            if (wr_en) begin
                if (!wr_addr) m_presc = wr_data & 63;
                else begin
                    m_trip = wr_data[7];
                    m_s2 = (wr_data >> 4) & 7;
                    m_s1 = wr_data & 15;
                end
            end
        end else begin
            int p, pos;
            p = m_presc + 1;
            pos = k % bit_len();
            exp_s = 0;
            if (pos == m_s1 * p - 1) sa = rx_in;
            if (pos == (m_s1 + 1) * p - 1) sb = rx_in;
            if (pos == (m_s1 + 2) * p - 1) begin
                exp_s = 1;
                if (m_trip != 0 && m_s1 >= 1) exp_v = (sa + sb + int'(rx_in)) >= 2;
                else exp_v = rx_in;
            end
            k++;
        end
    end

    // Per-clock compare, spacing and glitch checks, then drive rx for the next edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk(bit_strobe === exp_s, "R4 R10 strobe timing", int'(bit_strobe), int'(exp_s));
            if (exp_s)
                chk(bit_value === exp_v, "R5 R6 bit value", int'(bit_value), int'(exp_v));
            if (init_req && init_ack) last_sp = -1;
            else if (bit_strobe) begin
                if (last_sp >= 0)
                    chk(cyc - last_sp == bit_len(), "R2 R3 strobe spacing", cyc - last_sp, bit_len());
                last_sp = cyc;
            end
            if (glit_en && bit_strobe)
                chk(bit_value === glit_exp, glit_tag, int'(bit_value), int'(glit_exp));
        end
        if (glit_en) rx_in = glit_base ^ ((k % bit_len()) == glit_pos);
        else rx_in = 1'($urandom % 2);
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input bit a, input logic [7:0] expv, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(rd_data === expv, tag, int'(rd_data), int'(expv));
    endtask

    task automatic set_cfg(input logic [7:0] presc, input logic [7:0] tim);
        @(negedge clk); init_req = 1; init_ack = 1;
        @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = presc;
        @(negedge clk); wr_addr = 1; wr_data = tim;
        @(negedge clk); wr_en = 0;
        wait_cyc(3);
        init_req = 0; init_ack = 0;
    endtask

    task automatic glitch_run(input int pos, input bit expv, input string tag, input int n);
        @(negedge clk);
        glit_pos = pos; glit_exp = expv; glit_tag = tag; glit_base = 1; glit_en = 1;
        wait_cyc(n);
        glit_en = 0;
    endtask

    initial begin
        wait_cyc(4);
        chk(bit_strobe === 1'b0, "R1 strobe low in reset", int'(bit_strobe), 0);
        rst_n = 1;
        rd_chk(0, 8'h00, "R1 prescaler reset");
        rd_chk(1, 8'h00, "R1 timing reset");

        // Smallest quantum, short segments, random line.
        set_cfg(8'h00, 8'h12);
        rd_chk(1, 8'h12, "R8 timing readback");
        wait_cyc(300);

        // Upper prescaler bits ignored; longest bit time.
        set_cfg(8'hFF, 8'h7F);
        rd_chk(0, 8'h3F, "R2 prescaler field bits 5:0");
        wait_cyc(4000);

        // Triple sampling, P=2, seg1=3, seg2=2: vote edges at 5, 7, 9 of 16.
        set_cfg(8'h01, 8'hA3);
        wait_cyc(400);
        rd_chk(1, 8'hA3, "R8 readback while running");
        set_cfg(8'h01, 8'hA3);
        glitch_run(9, 1, "R6 majority masks glitch at sample point", 100);
        set_cfg(8'h01, 8'hA3);
        glitch_run(5, 1, "R6 majority masks glitch at first vote", 100);

        // Single sampling shows the glitch.
        set_cfg(8'h01, 8'h23);
        glitch_run(9, 0, "R5 single sample follows line", 100);

        // Triple requested with a one-quantum first segment: falls back to single.
        set_cfg(8'h01, 8'hA0);
        glitch_run(3, 0, "R7 fallback to single sample", 100);

        // Writes without full init handshake are ignored.
        @(negedge clk); init_req = 1; init_ack = 0; wr_en = 1; wr_addr = 0; wr_data = 8'h05;
        @(negedge clk); init_req = 0; init_ack = 1; wr_addr = 1; wr_data = 8'h11;
        @(negedge clk); init_ack = 0; wr_addr = 0; wr_data = 8'h22;
        @(negedge clk); wr_en = 0;
        rd_chk(0, 8'h01, "R9 prescaler unchanged");
        rd_chk(1, 8'hA0, "R9 timing unchanged");
        wait_cyc(200);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule